// File: doc/BRIEF.md
# Decode-Stage Wrong-Path Filter with Early Redirect

This block sits in the decode stage of a pipelined processor. Each instruction from fetch carries two epoch tags: the fetch unit's guess of the execute epoch and its guess of the decode epoch. The block holds its own estimate of the execute epoch and the authoritative decode epoch. From these it decides whether an instruction is on the correct path. A wrong-path instruction is discarded. An instruction that survives has its fetch-predicted next PC compared against a next PC that the decode logic computes and presents on an input.

When the two PCs disagree, the block flips its decode epoch and sends a redirect message back to fetch. The message carries the instruction PC, the corrected target and the instruction's execute epoch. Surviving instructions pass on toward execute with the corrected target as their new prediction.

The execute epoch is never signalled directly. It is inferred from the instructions that arrive. When an instruction shows a new execute epoch, the block takes the decode epoch from that instruction instead of from its own register. A scoreboard hit, a busy execute side or a busy redirect channel holds the instruction in place.

Top module: `dec_epoch_filter`

## Requirements
- R1: After reset the execute-epoch estimate and the decode epoch are both 0, so an instruction tagged execute 0 / decode 0 is accepted and one tagged execute 0 / decode 1 is dropped. Epochs are EP_W bits wide (default 1), and flipping an epoch means adding one modulo 2^EP_W.
- R2: When the incoming execute epoch equals the estimate but the incoming decode epoch differs from the local one, the instruction is consumed (`in_ready`=1) in that cycle with no forward and no redirect, and neither epoch changes.
- R3: An accepted instruction is forwarded with `out_pc` = `in_pc`, `out_npc` = `dec_npc` and `out_eep` = `in_eep`.
- R4: For an accepted instruction in the matching case where `in_ppc` differs from `dec_npc`, the redirect carries `rd_pc` = `in_pc`, `rd_npc` = `dec_npc` and `rd_eep` = `in_eep`, and the local decode epoch flips.
- R5: When the incoming execute epoch differs from the estimate, the instruction is accepted whatever its decode epoch, and on transfer the estimate becomes the incoming execute epoch.
- R6: In that resynchronising case the new decode epoch is the instruction's decode epoch, flipped if `in_ppc` differs from `dec_npc`. A redirect is issued under the same rule as in R4.
- R7: While `sb_hit` is high, an instruction that would be accepted is not consumed, nothing is forwarded or redirected, and no epoch changes.
- R8: When an accepted instruction needs a redirect and `rd_ready` is low, the instruction is not consumed, `out_valid` is low and no epoch changes.
- R9: When `out_ready` is low, an accepted instruction is not consumed, `rd_valid` is low and no epoch changes.
- R10: At most one redirect transfers per cycle, and only in the same cycle as the forward transfer of the same instruction.
- R11: A dropped instruction is consumed even when `sb_hit` is high or `out_ready` / `rd_ready` are low. With `in_valid` low, all valid and ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction from fetch is present |
| in_ready | output | 1 | The instruction is consumed this cycle |
| in_pc | input | AW | Instruction PC |
| in_ppc | input | AW | Next PC predicted by fetch |
| in_eep | input | EP_W | Execute epoch tagged by fetch |
| in_dep | input | EP_W | Decode epoch tagged by fetch |
| dec_npc | input | AW | Next PC computed by the decode logic |
| sb_hit | input | 1 | A source register is busy in the scoreboard |
| out_valid | output | 1 | Forwarded instruction is valid |
| out_ready | input | 1 | Execute side can take the instruction |
| out_pc | output | AW | Forwarded PC |
| out_npc | output | AW | Forwarded next-PC prediction |
| out_eep | output | EP_W | Forwarded execute epoch |
| rd_valid | output | 1 | Redirect message is valid |
| rd_ready | input | 1 | Fetch can take the redirect |
| rd_pc | output | AW | PC of the redirecting instruction |
| rd_npc | output | AW | Corrected target |
| rd_eep | output | EP_W | Execute epoch of the redirecting instruction |

## Verification
The assertions assume that the instruction fields and `dec_npc` are stable and meaningful only while `in_valid` is high. They also assume that `sb_hit`, `out_ready` and `rd_ready` are plain level inputs sampled at the same clock edge. The bench sets every input once per cycle on the falling edge and leaves it alone until the next falling edge, so no input changes close to the sampling edge. Directed sequences cover each epoch case in turn. A random phase then mixes all epoch tags, PC agreements and back-pressure levels, and it does so only through legal single-cycle inputs.

// File: rtl/dec_epoch_pkg.sv
package dec_epoch_pkg;
  // classification of the instruction at the stage input
  typedef enum logic [1:0] {
    CLS_IDLE   = 2'd0,
    CLS_DROP   = 2'd1,
    CLS_KEEP   = 2'd2,
    CLS_RESYNC = 2'd3
  } cls_e;
endpackage

// File: rtl/epoch_judge.sv
module epoch_judge
  import dec_epoch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EP_W = 1
) (
  input  logic            in_valid,
  input  logic [AW-1:0]   in_ppc,
  input  logic [AW-1:0]   dec_npc,
  input  logic [EP_W-1:0] in_eep,
  input  logic [EP_W-1:0] in_dep,
  input  logic [EP_W-1:0] e_est,
  input  logic [EP_W-1:0] d_ep,
  output cls_e            cls,
  output logic            mispred,
  output logic [EP_W-1:0] nxt_eest,
  output logic [EP_W-1:0] nxt_dep
);
  function automatic logic [EP_W-1:0] epoch_flip(input logic [EP_W-1:0] x);
    return x + EP_W'(1);
  endfunction

  function automatic logic [EP_W-1:0] pick_dep(
    input logic            resync,
    input logic [EP_W-1:0] tag_dep,
    input logic [EP_W-1:0] own_dep,
    input logic            flip
  );
    logic [EP_W-1:0] base;
    base = resync ? tag_dep : own_dep;
    return flip ? epoch_flip(base) : base;
  endfunction

  always_comb begin
    if (!in_valid)            cls = CLS_IDLE;
    else if (in_eep != e_est) cls = CLS_RESYNC;
    else if (in_dep == d_ep)  cls = CLS_KEEP;
    else                      cls = CLS_DROP;
  end

  assign mispred  = (in_ppc != dec_npc);
  assign nxt_eest = in_eep;
  assign nxt_dep  = pick_dep(cls == CLS_RESYNC, in_dep, d_ep, mispred);
endmodule

// File: rtl/epoch_state.sv
module epoch_state #(
  parameter int EP_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic            resync,
  input  logic [EP_W-1:0] nxt_eest,
  input  logic [EP_W-1:0] nxt_dep,
  output logic [EP_W-1:0] e_est,
  output logic [EP_W-1:0] d_ep
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_est <= '0;
      d_ep  <= '0;
    end else if (commit) begin
      if (resync) e_est <= nxt_eest;
      d_ep <= nxt_dep;
    end
  end

  // no transfer, no epoch movement (R2, R7, R8, R9)
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(e_est) && $stable(d_ep)));
endmodule

// File: rtl/dec_flow_ctrl.sv
module dec_flow_ctrl
  import dec_epoch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  cls_e cls,
  input  logic mispred,
  input  logic sb_hit,
  input  logic out_ready,
  input  logic rd_ready,
  output logic in_ready,
  output logic out_valid,
  output logic rd_valid,
  output logic commit
);
  logic accept, drop_evt, go;

  assign accept    = in_valid && (cls == CLS_KEEP || cls == CLS_RESYNC);
  assign drop_evt  = in_valid && (cls == CLS_DROP);
  assign go        = accept && !sb_hit;
  assign out_valid = go && (!mispred || rd_ready);
  assign rd_valid  = go && mispred && out_ready;
  assign commit    = out_valid && out_ready;
  assign in_ready  = drop_evt || commit;

  assert_one_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |-> (out_valid && out_ready));

  assert_sb_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sb_hit) |-> (!in_ready && !out_valid && !rd_valid));

  assert_rd_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mispred && !rd_ready) |-> (!in_ready && !out_valid));

  assert_drop_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (in_ready && !out_valid && !rd_valid));
endmodule

// File: rtl/dec_epoch_filter.sv
module dec_epoch_filter
  import dec_epoch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EP_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_pc,
  input  logic [AW-1:0]   in_ppc,
  input  logic [EP_W-1:0] in_eep,
  input  logic [EP_W-1:0] in_dep,
  input  logic [AW-1:0]   dec_npc,
  input  logic            sb_hit,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_pc,
  output logic [AW-1:0]   out_npc,
  output logic [EP_W-1:0] out_eep,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_pc,
  output logic [AW-1:0]   rd_npc,
  output logic [EP_W-1:0] rd_eep
);
  cls_e            cls;
  logic            mispred, commit;
  logic [EP_W-1:0] e_est, d_ep, nxt_eest, nxt_dep;

  epoch_judge #(.AW(AW), .EP_W(EP_W)) judge_i (
    .in_valid(in_valid), .in_ppc(in_ppc), .dec_npc(dec_npc),
    .in_eep(in_eep), .in_dep(in_dep), .e_est(e_est), .d_ep(d_ep),
    .cls(cls), .mispred(mispred), .nxt_eest(nxt_eest), .nxt_dep(nxt_dep)
  );

  epoch_state #(.EP_W(EP_W)) state_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .resync(cls == CLS_RESYNC),
    .nxt_eest(nxt_eest), .nxt_dep(nxt_dep), .e_est(e_est), .d_ep(d_ep)
  );

  dec_flow_ctrl flow_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls),
    .mispred(mispred), .sb_hit(sb_hit), .out_ready(out_ready),
    .rd_ready(rd_ready), .in_ready(in_ready), .out_valid(out_valid),
    .rd_valid(rd_valid), .commit(commit)
  );

  assign out_pc  = in_pc;
  assign out_npc = dec_npc;
  assign out_eep = in_eep;
  assign rd_pc   = in_pc;
  assign rd_npc  = dec_npc;
  assign rd_eep  = in_eep;

  assert_resync_takes_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cls == CLS_RESYNC) |=> (e_est == $past(in_eep)));

  assert_mispred_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cls == CLS_KEEP && mispred) |=> (d_ep != $past(d_ep)));

  assert_resync_dep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cls == CLS_RESYNC && !mispred) |=> (d_ep == $past(in_dep)));
endmodule

// File: tb/dec_epoch_filter_tb_top.sv
module dec_epoch_filter_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, sb_hit = 1'b0, out_ready = 1'b0, rd_ready = 1'b0;
  logic [AW-1:0] in_pc = '0, in_ppc = '0, dec_npc = '0;
  logic          in_eep = 1'b0, in_dep = 1'b0;
  logic          in_ready, out_valid, rd_valid;
  logic [AW-1:0] out_pc, out_npc, rd_pc, rd_npc;
  logic          out_eep, rd_eep;

  always #10 clk = ~clk;

  dec_epoch_filter #(.AW(AW), .EP_W(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_ppc(in_ppc), .in_eep(in_eep), .in_dep(in_dep),
    .dec_npc(dec_npc), .sb_hit(sb_hit), .out_valid(out_valid),
    .out_ready(out_ready), .out_pc(out_pc), .out_npc(out_npc),
    .out_eep(out_eep), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_eep(rd_eep)
  );

  typedef struct {
    string         tag;
    logic          ir, ov, rv;
    logic [AW-1:0] pc, npc;
    logic          ep;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  logic m_eest = 1'b0, m_dep = 1'b0;
  bit   done = 1'b0;

  // driver: sets one cycle of inputs and predicts what the ports show
  task automatic apply(input string tag, input logic v, input logic [AW-1:0] pc,
                       input logic [AW-1:0] ppc, input logic [AW-1:0] npc,
                       input logic eep, input logic dep, input logic sb,
                       input logic ordy, input logic rrdy);
    exp_t e;
    logic resync, acc, mis, go, com;
    @(negedge clk);
    in_valid = v; in_pc = pc; in_ppc = ppc; dec_npc = npc;
    in_eep = eep; in_dep = dep; sb_hit = sb; out_ready = ordy; rd_ready = rrdy;
    e.tag = tag; e.pc = pc; e.npc = npc; e.ep = eep;
    e.ir = 1'b0; e.ov = 1'b0; e.rv = 1'b0;
    if (v) begin
      resync = (eep != m_eest);
      acc    = resync || (dep == m_dep);
      mis    = (ppc != npc);
      if (!acc) e.ir = 1'b1;
      else begin
        go   = !sb;
        e.ov = go && (!mis || rrdy);
        e.rv = go && mis && ordy;
        com  = e.ov && ordy;
        e.ir = com;
        if (com) begin
          if (resync) begin
            m_eest = eep;
            m_dep  = dep ^ mis;
          end else m_dep = m_dep ^ mis;
        end
      end
    end
    q.push_back(e);
  endtask

  // monitor: compares ahead of the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = (in_ready !== e.ir) || (out_valid !== e.ov) || (rd_valid !== e.rv);
        if (e.ov && (out_pc !== e.pc || out_npc !== e.npc || out_eep !== e.ep)) bad = 1;
        if (e.rv && (rd_pc !== e.pc || rd_npc !== e.npc || rd_eep !== e.ep)) bad = 1;
        n_chk++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s: got rdy=%b ov=%b rv=%b out=%h/%h/%b rd=%h/%h/%b exp rdy=%b ov=%b rv=%b pc=%h npc=%h ep=%b",
                   e.tag, in_ready, out_valid, rd_valid, out_pc, out_npc, out_eep,
                   rd_pc, rd_npc, rd_eep, e.ir, e.ov, e.rv, e.pc, e.npc, e.ep);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    apply("R11 idle", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    apply("R1 reset accept", 1, 32'h100, 32'h104, 32'h104, 0, 0, 0, 1, 1);
    apply("R1 R2 reset drop", 1, 32'h104, 32'h108, 32'h108, 0, 1, 0, 1, 1);
    apply("R3 forward", 1, 32'h108, 32'h10c, 32'h10c, 0, 0, 0, 1, 1);
    apply("R4 redirect", 1, 32'h10c, 32'h200, 32'h300, 0, 0, 0, 1, 1);
    apply("R4 old dep dropped", 1, 32'h200, 32'h204, 32'h204, 0, 0, 0, 1, 1);
    apply("R3 new dep kept", 1, 32'h300, 32'h304, 32'h304, 0, 1, 0, 1, 1);
    apply("R8 rd backpressure", 1, 32'h304, 32'h400, 32'h500, 0, 1, 0, 1, 0);
    apply("R8 epoch unchanged", 1, 32'h304, 32'h308, 32'h308, 0, 1, 0, 1, 1);
    apply("R7 sb stall", 1, 32'h308, 32'h30c, 32'h30c, 0, 1, 1, 1, 1);
    apply("R7 epoch unchanged", 1, 32'h308, 32'h30c, 32'h30c, 0, 0, 0, 1, 1);
    apply("R9 out backpressure", 1, 32'h30c, 32'h600, 32'h700, 0, 1, 0, 0, 1);
    apply("R11 drop under stall", 1, 32'h310, 32'h314, 32'h314, 0, 0, 1, 0, 0);
    apply("R5 resync any dep", 1, 32'h800, 32'h804, 32'h804, 1, 0, 0, 1, 1);
    apply("R5 estimate moved", 1, 32'h804, 32'h808, 32'h808, 1, 1, 0, 1, 1);
    apply("R6 resync mispred", 1, 32'h900, 32'h904, 32'ha00, 0, 1, 0, 1, 1);
    apply("R6 dep from tag flipped", 1, 32'ha00, 32'ha04, 32'ha04, 0, 1, 0, 1, 1);
    apply("R6 dep from tag kept", 1, 32'ha04, 32'ha08, 32'ha08, 0, 0, 0, 1, 1);
    apply("R10 rd and fwd together", 1, 32'ha08, 32'hb00, 32'hc00, 0, 0, 0, 1, 1);
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] p;
      p = $urandom;
      apply("R10 mixed", ($urandom % 8) != 0, p, p + 4, ($urandom % 3 == 0) ? p + 64 : p + 4,
            1'($urandom), 1'($urandom), ($urandom % 4) == 0,
            ($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule